// File: doc/BRIEF.md
# Dual-Reload Down-Counting PWM Timer

This block is one timer channel clocked by a free-running input clock. A down-counter runs through two phases in turn. The low phase lasts as long as the low-count register says. In PWM mode the high phase lasts as long as the high-count register says. The output level flips each time the counter reaches zero, so a pair of 32-bit values sets the duty cycle and the period independently. With PWM mode off, only the low-count value is used for both phases, which gives a symmetric square wave.

Software programs the channel through a plain write port. There is one register for each count and a control word with three bits: enable, reload-from-register mode, and PWM mode. The normal sequence is to disable the channel, write the counts, and enable it again. A new low count written while the channel is running is still picked up at the next reload. A one-cycle expiry pulse marks the last cycle of every phase.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset, both count registers and the control word are zero, `pwmOut` is 0 and `expiry` is 0.
- R2: With the control word at 3'b111, phases alternate, and a count of 0 gives a one-cycle phase. Each low phase lasts low count + 1 cycles and each high phase lasts high count + 1 cycles. Control bit 0 is enable, bit 1 is reload-from-register and bit 2 is PWM. Address 0 is the low count, address 1 the high count and address 2 the control word.
- R3: Setting the enable bit starts the channel. The counter loads the low count on the clock edge after the edge that stores the enable bit. The first phase is the low phase, and `pwmOut` first rises low count + 1 cycles after that load.
- R4: With bit 1 set and bit 2 clear, every reload takes the low count and the high-count register has no effect. Both phases then last low count + 1 cycles.
- R5: `expiry` is high for exactly the one cycle in which the running counter is at 0. `pwmOut` changes level on the edge that ends that cycle, and the counter reloads on the same edge.
- R6: A low count written while the channel runs is used at the next low-phase reload, with no disable/enable cycle needed. When two writes come back to back, the later value wins.
- R7: While enable is clear, `pwmOut` is 0 from the cycle after the disabling write, no expiry occurs and the counter holds its value. Enabling again restarts with a low phase loaded from the low count.
- R8: With bit 1 clear (free-running), a zero count reloads to all ones instead of a register value. After the first low phase, the output therefore stays high with no expiry for 2^32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 low count, 1 high count, 2 control |
| wrData | input | 32 | Write data |
| pwmOut | output | 1 | Timer output level |
| expiry | output | 1 | One-cycle pulse in the last cycle of each phase |

## Verification
The bench measures phase widths at count 0, where an off-by-one design would give a two-cycle phase or stall. It also measures the startup delay after enable, which a design loading at the enable edge itself would shorten by one cycle. It rewrites the low count twice in a row while running: a design that latched the count only at enable would keep the old width, and one that took the first write would show the wrong value. Non-PWM mode, disable/re-enable and free-running wrap are also checked, because a design that reads the high count by mistake or fails to drive the output low while disabled gives visibly wrong widths and levels.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam int CTRL_W   = 3;
  localparam int BIT_EN   = 0;
  localparam int BIT_USER = 1;
  localparam int BIT_PWM  = 2;

  typedef enum logic [1:0] {SRC_LOW, SRC_HIGH, SRC_MAX} srcSel_e;

  typedef struct packed {
    logic    load;
    logic    dec;
    logic    reload;
    srcSel_e src;
  } cntCmd_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic              cntZero,
  output cntCmd_t           cmd,
  output logic              pwmOut,
  output logic              expiry
);
  logic enQ, userQ, pwmQ, runQ, levelQ;
  logic ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign expiry = enQ && runQ && cntZero;
  assign pwmOut = levelQ && enQ;

  always_comb begin
    cmd.load   = enQ && !runQ;
    cmd.reload = expiry;
    cmd.dec    = enQ && runQ && !cntZero;
    if (!userQ)               cmd.src = SRC_MAX;
    else if (pwmQ && !levelQ) cmd.src = SRC_HIGH;
    else                      cmd.src = SRC_LOW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      userQ  <= 1'b0;
      pwmQ   <= 1'b0;
      runQ   <= 1'b0;
      levelQ <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enQ   <= wrCtrl[BIT_EN];
        userQ <= wrCtrl[BIT_USER];
        pwmQ  <= wrCtrl[BIT_PWM];
      end
      runQ <= enQ;
      if (!enQ || !runQ) levelQ <= 1'b0;
      else if (expiry)   levelQ <= ~levelQ;
    end
  end

  // R5: the output flips on the edge that ends an expiry cycle
  assert_toggle_on_expiry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (expiry && !ctrlWr) |=> (levelQ != $past(levelQ)));
  // R7: an idle channel drives low and never expires
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ) |=> (!levelQ && !expiry));
  // R3: a fresh start always begins in the low phase
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !runQ) |=> !levelQ);
endmodule

// File: rtl/pwm_timer_dpath.sv
module pwm_timer_dpath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  cntCmd_t           cmd,
  output logic              cntZero
);
  localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ALL_ON = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lowQ, highQ, cntQ, reloadVal;

  assign cntZero = (cntQ == '0);

  always_comb begin
    unique case (cmd.src)
      SRC_HIGH: reloadVal = highQ;
      SRC_MAX:  reloadVal = ALL_ON;
      default:  reloadVal = lowQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ  <= '0;
      highQ <= '0;
      cntQ  <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_LOW)  lowQ  <= wrData;
      if (wrEn && wrAddr == ADDR_HIGH) highQ <= wrData;
      if (cmd.load)        cntQ <= lowQ;
      else if (cmd.reload) cntQ <= reloadVal;
      else if (cmd.dec)    cntQ <= cntQ - ONE;
    end
  end

  // R3: a start loads the low count
  assert_start_from_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (cntQ == $past(lowQ)));
  // R2: a high-phase reload takes the high count
  assert_high_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.reload && cmd.src == SRC_HIGH) |=> (cntQ == $past(highQ)));
  // R2: running counter steps down by one
  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |=> (cntQ == $past(cntQ) - ONE));
  // R7: no command, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.load || cmd.reload || cmd.dec) |=> $stable(cntQ));
  // R8: free-running wrap goes to all ones
  assert_free_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.reload && cmd.src == SRC_MAX) |=> (cntQ == ALL_ON));
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut,
  output logic              expiry
);
  cntCmd_t cmd;
  logic    cntZero;

  pwm_timer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrCtrl (wrData[CTRL_W-1:0]),
    .cntZero(cntZero),
    .cmd    (cmd),
    .pwmOut (pwmOut),
    .expiry (expiry)
  );

  pwm_timer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cmd    (cmd),
    .cntZero(cntZero)
  );
endmodule

// File: tb/sim_pwm_reload_timer.sv
`timescale 1ns/1ps
module sim_pwm_reload_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        pwmOut, expiry;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwm_reload_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .expiry(expiry)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase state and remaining cycles
  bit mEn, mUser, mPwm, mRun, mLevel;
  longint unsigned mLow, mHigh, mLeft;
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mUser = 0; mPwm = 0; mRun = 0; mLevel = 0;
      mLow = 0; mHigh = 0; mLeft = 0;
    end else begin
      if (!mEn) begin
        mRun = 0; mLevel = 0;
      end else if (!mRun) begin
        mRun = 1; mLeft = mLow; mLevel = 0;
      end else if (mLeft == 0) begin
        if (!mUser) mLeft = 64'hFFFF_FFFF;
        else if (mPwm && !mLevel) mLeft = mHigh;
        else mLeft = mLow;
        mLevel = !mLevel;
      end else begin
        mLeft = mLeft - 1;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mLow  = wrData;
          2'd1: mHigh = wrData;
          2'd2: begin mEn = wrData[0]; mUser = wrData[1]; mPwm = wrData[2]; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(pwmOut === (mLevel && mEn), "R2 R7 level vs model", pwmOut, mLevel && mEn);
      check(expiry === (mEn && mRun && mLeft == 0), "R5 expiry vs model", expiry, mEn && mRun && mLeft == 0);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        nFails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // length of the next complete run at the given level
  task automatic fullRun(input logic lvl, output int n);
    n = 0;
    while (pwmOut === lvl) @(negedge clk);
    while (pwmOut !== lvl) @(negedge clk);
    while (pwmOut === lvl) begin n++; @(negedge clk); end
  endtask

  // run counted from now, starting at the current level
  task automatic runFromNow(output int n);
    logic lvl;
    lvl = pwmOut;
    n = 0;
    while (pwmOut === lvl) begin n++; @(negedge clk); end
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check(pwmOut === 1'b0, "R1 reset pwmOut", pwmOut, 0);
    check(expiry === 1'b0, "R1 reset expiry", expiry, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(pwmOut === 1'b0, "R1 idle after reset", pwmOut, 0);

    // R3 and R2: low 3, high 5, PWM with register reload
    writeReg(2'd0, 32'd3);
    writeReg(2'd1, 32'd5);
    writeReg(2'd2, 32'h7);
    runFromNow(w);
    check(w == 5, "R3 startup low run", w, 5);
    for (int i = 0; i < 3; i++) begin
      fullRun(1'b1, w); check(w == 6, "R2 high width", w, 6);
      fullRun(1'b0, w); check(w == 4, "R2 low width", w, 4);
    end

    // R2: zero counts give one-cycle phases
    writeReg(2'd0, 32'd0);
    writeReg(2'd1, 32'd0);
    repeat (12) @(negedge clk);
    fullRun(1'b1, w); check(w == 1, "R2 high width at count 0", w, 1);
    fullRun(1'b0, w); check(w == 1, "R2 low width at count 0", w, 1);

    // R6: back-to-back low updates while running
    writeReg(2'd1, 32'd2);
    writeReg(2'd0, 32'd2);
    writeReg(2'd0, 32'd7);
    repeat (20) @(negedge clk);
    fullRun(1'b0, w); check(w == 8, "R6 low width after live update", w, 8);
    fullRun(1'b1, w); check(w == 3, "R6 high width unchanged", w, 3);

    // R4: non-PWM square wave ignores high count
    writeReg(2'd2, 32'h0);
    writeReg(2'd0, 32'd4);
    writeReg(2'd1, 32'd9);
    writeReg(2'd2, 32'h3);
    for (int i = 0; i < 2; i++) begin
      fullRun(1'b1, w); check(w == 5, "R4 high width uses low count", w, 5);
      fullRun(1'b0, w); check(w == 5, "R4 low width", w, 5);
    end

    // R7: disable forces low, then restart
    writeReg(2'd2, 32'h0);
    for (int i = 0; i < 20; i++) begin
      check(pwmOut === 1'b0 && expiry === 1'b0, "R7 disabled quiet", {pwmOut, expiry}, 0);
      @(negedge clk);
    end
    writeReg(2'd0, 32'd2);
    writeReg(2'd1, 32'd1);
    writeReg(2'd2, 32'h7);
    runFromNow(w);
    check(w == 4, "R7 restart low run", w, 4);
    runFromNow(w);
    check(w == 2, "R7 restart high width", w, 2);

    // R8: free-running mode wraps to all ones
    writeReg(2'd2, 32'h0);
    writeReg(2'd2, 32'h5);
    runFromNow(w);
    check(w == 4, "R8 first low run", w, 4);
    for (int i = 0; i < 200; i++) begin
      check(pwmOut === 1'b1 && expiry === 1'b0, "R8 long high, no expiry", {pwmOut, expiry}, 2);
      @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule